// File: doc/BRIEF.md
# Fused add-shift sequential multiplier

This block multiplies two unsigned N-bit operands over N clock cycles by treating one multiplier bit per cycle. The host places the multiplicand on the shared operand bus and pulses `ld_mcand`, then places the multiplier on the bus and pulses `ld_mplier`, then raises `start` for one cycle while the block is idle. The 2N-bit product is always visible on `prod`, and `idle` goes high again when the result is complete.

Each working cycle does the whole step at once. The multiplicand is added to the accumulator when the current low multiplier bit is 1, and zero is added when it is 0. The N+1-bit sum, with its carry on top, is then shifted right together with the multiplier register. The carry goes straight into the top of the accumulator, so no carry flip-flop is kept between cycles. A down counter loaded with N-1 is tested for zero before it is decremented, which ends the loop after exactly N steps.

Top module: `fused_mult`

## Requirements
- R1: After reset, `idle` is 1 and `prod` is all zeros.
- R2: When `start` is 1 while `idle` is 1, the upper half of `prod` (the accumulator) is zero on the next cycle and `idle` falls.
- R3: After the clock edge that accepts `start`, `idle` stays low for exactly N cycles and is high again after the (N+1)-th edge.
- R4: When `idle` returns, `prod` equals the unsigned product of the last captured multiplicand and multiplier, including all-ones times all-ones, where the adder carry must reach the accumulator MSB.
- R5: In every busy cycle, the lower N-1 bits of `prod` become the previous bits N-1 down to 1, so the multiplier is consumed from its LSB.
- R6: While `idle` is 1, `ld_mcand` captures `opnd` as the multiplicand and `ld_mplier` captures `opnd` into the multiplier register (the lower half of `prod`).
- R7: While `idle` is 0, `start`, `ld_mcand` and `ld_mplier` have no effect on the result or on the cycle count.
- R8: While `idle` is 1 and neither `start` nor `ld_mplier` is asserted, `prod` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Begin a multiply (accepted in idle only) |
| ld_mcand | input | 1 | Capture `opnd` as multiplicand (idle only) |
| ld_mplier | input | 1 | Capture `opnd` as multiplier (idle only) |
| opnd | input | N | Shared operand bus |
| prod | output | 2N | Accumulator and multiplier register, concatenated |
| idle | output | 1 | High when no multiply is in progress |

## Verification
On every cycle the assertions check the accumulator clear at start, the right shift of the low half during busy cycles, the exact busy length of N cycles tracked with a counter, and that the product holds in idle. Arithmetic correctness, including the carry reaching the accumulator MSB and load or start pulses being ignored mid-run, is shown only by the bench's scenarios. These are exhaustive for N = 4, with random disturbed runs added.

// File: rtl/fused_mult.sv
module fused_mult #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           ld_mcand,
  input  logic           ld_mplier,
  input  logic [N-1:0]   opnd,
  output logic [2*N-1:0] prod,
  output logic           idle
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} st_t;

  st_t           st;
  logic [N-1:0]  acc, mcand, mplier;
  logic [PW-1:0] cnt;
  logic [N:0]    sum;
  logic          last;

  assign last = ~|cnt;
  assign sum  = {1'b0, acc} + {1'b0, (mplier[0] ? mcand : '0)};
  assign prod = {acc, mplier};
  assign idle = (st == S_IDLE);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st     <= S_IDLE;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      cnt    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ld_mcand)  mcand  <= opnd;
          if (ld_mplier) mplier <= opnd;
          if (start) begin
            acc <= '0;
            cnt <= PW'(N - 1);
            st  <= S_RUN;
          end
        end
        S_RUN: begin
          acc    <= sum[N:1];
          mplier <= {sum[0], mplier[N-1:1]};
          cnt    <= cnt - 1'b1;
          if (last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module fused_mult_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           ld_mplier,
  input logic [2*N-1:0] prod,
  input logic           idle
);
  int busy_n;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       busy_n <= 0;
    else if (idle) busy_n <= 0;
    else           busy_n <= busy_n + 1;
  end

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
    idle && start |=> !idle && prod[2*N-1:N] == '0);

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> busy_n == N);

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (rst)
    !idle |-> busy_n < N);

  assert_shift_R5: assert property (@(posedge clk) disable iff (rst)
    !idle |=> prod[N-2:0] == $past(prod[N-1:1]));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    idle && !start && !ld_mplier |=> idle && $stable(prod));
endmodule

bind fused_mult fused_mult_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ld_mplier(ld_mplier),
  .prod(prod), .idle(idle)
);

// File: tb/tb_fused_mult.sv
module tb_fused_mult;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0, ld_mcand = 1'b0, ld_mplier = 1'b0;
  logic [N-1:0]   opnd = '0;
  logic [2*N-1:0] prod;
  logic           idle;
  int total = 0, bad = 0;

  fused_mult #(.N(N)) dut (
    .clk(clk), .rst(rst), .start(start), .ld_mcand(ld_mcand),
    .ld_mplier(ld_mplier), .opnd(opnd), .prod(prod), .idle(idle)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2*N-1:0] exp_prod(logic [N-1:0] a, logic [N-1:0] b);
    return (2*N)'(a) * (2*N)'(b);
  endfunction

  task automatic check(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(logic [N-1:0] a, logic [N-1:0] b, bit disturb);
    @(negedge clk); opnd = a; ld_mcand = 1'b1;
    @(negedge clk); ld_mcand = 1'b0; opnd = b; ld_mplier = 1'b1;
    @(negedge clk); check("R6", {{N{1'b0}}, prod[N-1:0]}, {{N{1'b0}}, b});
    ld_mplier = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2", {prod[2*N-1:N], {(N-1){1'b0}}, idle}, '0);
    if (disturb) begin
      ld_mcand = 1'b1; ld_mplier = 1'b1; start = 1'b1; opnd = ~a;
    end
    for (int i = 1; i < N; i++) @(negedge clk);
    ld_mcand = 1'b0; ld_mplier = 1'b0; start = 1'b0;
    check("R3 busy", {{(2*N-1){1'b0}}, idle}, '0);
    @(negedge clk);
    check("R3 done", {{(2*N-1){1'b0}}, idle}, 1);
    check(disturb ? "R7" : "R4", prod, exp_prod(a, b));
  endtask

  initial begin
    int guard = 0;
    forever begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [2*N-1:0] held;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1", {prod[2*N-1:1], idle}, 1);
    rst = 1'b0;
    // corners
    run('1, '1, 1'b0);
    run('1, 1, 1'b0);
    run(0, '1, 1'b0);
    run('1, '1, 1'b1);
    // exhaustive
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << N); b++)
        run(N'(a), N'(b), 1'b0);
    // random with mid-run disturbance
    for (int k = 0; k < 100; k++)
      run(N'($urandom), N'($urandom), 1'($urandom));
    // idle hold
    held = prod;
    opnd = ~opnd;
    repeat (3) @(negedge clk);
    check("R8", prod, held);
    check("R8 idle", {{(2*N-1){1'b0}}, idle}, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule